// File: doc/BRIEF.md
# DTMF Tone-Pair Period Classifier

This block takes two limited square waves, one carrying the low-frequency tone group and one the high-frequency tone group, and names the key they encode. Each input passes through a two-flop synchronizer, and a rising-edge detector follows it. A per-group counter measures the clock cycles between consecutive rising edges. The block compares each measured period with four precomputed windows, one for each nominal tone of that group.

A group becomes valid only after a run of consecutive periods falls in the same window. A stray period ends the run, and so does a silent input that outlasts a timeout. The signal-condition output is high while both groups are valid. While it is high, the 4-bit key code of the tone pair is presented, following the standard keypad coding. It is a front-end detector: duration guarding and bus output belong to the logic downstream.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: For a group tone of nominal frequency f, a measured period P (in clock cycles) falls in that tone's window when floor(CLK_HZ*40/(f*41)) <= P <= floor(CLK_HZ*40/(f*39)). These are the bounds for a deviation of about 2.5%. A tone within 1.5% + 2 Hz of nominal is therefore accepted, and one that deviates by 3.5% or more is rejected. Low tones are 697, 770, 852 and 941 Hz, and high tones are 1209, 1336, 1477 and 1633 Hz. Each group indexes its tones 0..3 in ascending frequency.
- R2: Each input is synchronized by two flops before its rising edges are detected. A period is the number of cycles between two detected rising edges. After reset or after a timeout, the first edge only starts a measurement.
- R3: A group becomes valid once MATCH_N consecutive periods (default 4) fall in the same tone's window.
- R4: A period that falls in a different tone's window restarts the run at one, so the group is not valid until MATCH_N periods of the new tone have been seen.
- R5: A period outside every window of the group clears the group's run and its valid status on the next clock.
- R6: If a group sees no rising edge for floor(CLK_HZ*1035/(f_low*1000)) cycles, it loses valid status and must re-arm. Here f_low is the group's lowest tone. The group does not drop before that count is reached.
- R7: sig_cond is high in exactly those cycles where both groups are valid. It falls as soon as either group loses validity.
- R8: While sig_cond is high, key carries the code for the low row and high column, using this keypad grid: 697 Hz gives 1,2,3,A; 770 Hz gives 4,5,6,B; 852 Hz gives 7,8,9,C; 941 Hz gives *,0,#,D. The columns are 1209, 1336, 1477 and 1633 Hz. Digits 1-9 code as their value, 0 as 1010, * as 1011, # as 1100, A, B and C as 1101, 1110 and 1111, and D as 0000.
- R9: key is 0000 whenever sig_cond is low.
- R10: After reset, sig_cond is low and key is 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_sq | input | 1 | Limited square wave of the low tone group |
| hi_sq | input | 1 | Limited square wave of the high tone group |
| sig_cond | output | 1 | Both groups hold a valid tone |
| key | output | 4 | Key code of the current tone pair, zero when idle |

## Verification
On every cycle, the assertions check the following group-level rules. A stray period or a timeout clears validity on the next clock. Validity can only rise on a measured period that hit a window. Switching to another tone's window drops validity. A stable pair holds a stable key. The bench alone shows the cases that depend on real tone streams. These are the complete 16-entry key map, accept and reject behaviour at the tolerance edges, and the exact count of periods needed before validity. The bench also shows the timeout's exact cycle position, which it does by comparing against its own cycle-level model throughout.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  // Nominal tone in Hz, index 0..3 ascending within its group.
  function automatic int tone_hz(input bit high_group, input int idx);
    int f;
    if (!high_group) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Shortest period accepted: frequency up by 1/40.
  function automatic int win_min(input int clk_hz, input int f);
    return int'((longint'(clk_hz) * 40) / (longint'(f) * 41));
  endfunction

  // Longest period accepted: frequency down by 1/40.
  function automatic int win_max(input int clk_hz, input int f);
    return int'((longint'(clk_hz) * 40) / (longint'(f) * 39));
  endfunction

  // Silence limit: lowest tone's period stretched by 3.5%.
  function automatic int silence_limit(input int clk_hz, input int f);
    return int'((longint'(clk_hz) * 1035) / (longint'(f) * 1000));
  endfunction

  // Keypad code from row (low tone) and column (high tone).
  function automatic logic [3:0] pair_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] c;
    if (col == 2'd3)       c = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
    else if (row != 2'd3)  c = 4'd1 + {2'b00, row} * 4'd3 + {2'b00, col};
    else begin
      case (col)
        2'd0:    c = 4'd11;
        2'd1:    c = 4'd10;
        default: c = 4'd12;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/tone_edge_sync.sv
module tone_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= sq_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tone_group_classifier.sv
module tone_group_classifier
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ     = 3579545,
  parameter int MATCH_N    = 4,
  parameter bit HIGH_GROUP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  output logic       valid,
  output logic [1:0] idx
);
  localparam int TMO    = silence_limit(CLK_HZ, tone_hz(HIGH_GROUP, 0));
  localparam int CW     = $clog2(TMO + 1);
  localparam int RW     = $clog2(MATCH_N + 1);
  localparam int NTONES = 4;

  logic [CW-1:0] cnt;
  logic          armed;
  logic [RW-1:0] run;
  logic [1:0]    last;
  logic          valid_q;

  logic [NTONES-1:0] hit_vec;
  logic              hit;
  logic [1:0]        hit_idx;
  logic              measure_evt;
  logic              tmo_evt;
  logic              same_tone;
  logic [RW-1:0]     run_next;

  for (genvar i = 0; i < NTONES; i++) begin : g_win
    localparam int PMIN = win_min(CLK_HZ, tone_hz(HIGH_GROUP, i));
    localparam int PMAX = win_max(CLK_HZ, tone_hz(HIGH_GROUP, i));
    assign hit_vec[i] = (cnt >= CW'(PMIN)) && (cnt <= CW'(PMAX));
  end

  always_comb begin
    hit_idx = 2'd0;
    for (int i = NTONES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = 2'(i);
  end

  assign hit         = |hit_vec;
  assign measure_evt = rise && armed;
  assign tmo_evt     = !rise && armed && (cnt >= CW'(TMO));
  assign same_tone   = (run != '0) && (hit_idx == last);
  assign run_next    = !same_tone ? RW'(1) :
                       (run == RW'(MATCH_N)) ? run : run + RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      run     <= '0;
      last    <= 2'd0;
      valid_q <= 1'b0;
    end else if (rise) begin
      cnt   <= CW'(1);
      armed <= 1'b1;
      if (armed) begin
        if (hit) begin
          run     <= run_next;
          last    <= hit_idx;
          valid_q <= (run_next == RW'(MATCH_N));
        end else begin
          run     <= '0;
          valid_q <= 1'b0;
        end
      end
    end else if (tmo_evt) begin
      armed   <= 1'b0;
      run     <= '0;
      valid_q <= 1'b0;
    end else if (cnt < CW'(TMO)) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign valid = valid_q;
  assign idx   = last;

  // R5: a stray period clears validity on the next clock
  a_r5_stray_clears: assert property (@(posedge clk) disable iff (!rst_n)
    measure_evt && !hit |=> !valid);

  // R6: silence past the limit clears validity
  a_r6_silence_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !valid);

  // R3: validity only appears after a measured period that hit a window
  a_r3_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(measure_evt && hit));

  // R4: a period in another tone's window drops validity
  a_r4_switch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (MATCH_N > 1) && measure_evt && hit && valid && (hit_idx != last) |=> !valid);
endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ  = 3579545,
  parameter int MATCH_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_sq,
  input  logic       hi_sq,
  output logic       sig_cond,
  output logic [3:0] key
);
  logic       lo_rise, hi_rise;
  logic       lo_valid, hi_valid;
  logic [1:0] lo_idx, hi_idx;

  tone_edge_sync u_lo_sync (.clk(clk), .rst_n(rst_n), .sq_in(lo_sq), .rise(lo_rise));
  tone_edge_sync u_hi_sync (.clk(clk), .rst_n(rst_n), .sq_in(hi_sq), .rise(hi_rise));

  tone_group_classifier #(.CLK_HZ(CLK_HZ), .MATCH_N(MATCH_N), .HIGH_GROUP(1'b0)) u_lo_grp (
    .clk(clk), .rst_n(rst_n), .rise(lo_rise), .valid(lo_valid), .idx(lo_idx));

  tone_group_classifier #(.CLK_HZ(CLK_HZ), .MATCH_N(MATCH_N), .HIGH_GROUP(1'b1)) u_hi_grp (
    .clk(clk), .rst_n(rst_n), .rise(hi_rise), .valid(hi_valid), .idx(hi_idx));

  assign sig_cond = lo_valid & hi_valid;
  assign key      = sig_cond ? pair_code(lo_idx, hi_idx) : 4'd0;

  // R8: a held tone pair holds its key
  a_r8_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sig_cond && $past(sig_cond) && $stable(lo_idx) && $stable(hi_idx) |-> $stable(key));

  // R7: losing either group drops the signal condition at once
  a_r7_drop_either: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_valid) || $fell(hi_valid) |-> !sig_cond);
endmodule

// File: tb/dtmf_pair_decoder_test.sv
module dtmf_pair_decoder_test;
  localparam int  CLK_HZ  = 357954;
  localparam int  MATCH_N = 4;
  localparam time TCLK    = 10ns;

  logic clk = 0, rst_n = 0, lo_sq = 0, hi_sq = 0;
  logic sig_cond;
  logic [3:0] key;

  dtmf_pair_decoder #(.CLK_HZ(CLK_HZ), .MATCH_N(MATCH_N)) uut (
    .clk(clk), .rst_n(rst_n), .lo_sq(lo_sq), .hi_sq(hi_sq), .sig_cond(sig_cond), .key(key));

  always #(TCLK/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  int freqs[2][4] = '{'{697, 770, 852, 941}, '{1209, 1336, 1477, 1633}};
  string grid = "123A456B789C*0#D";

  function automatic int char_code(byte ch);
    if (ch >= "1" && ch <= "9") return ch - "0";
    if (ch == "0") return 10;
    if (ch == "*") return 11;
    if (ch == "#") return 12;
    if (ch == "D") return 0;
    return ch - "A" + 13;
  endfunction

  function automatic int per_of(real f);
    return $rtoi(CLK_HZ / f + 0.5);
  endfunction

  // tone generators
  bit en[2] = '{0, 0};
  int per[2] = '{500, 250};
  int ph[2] = '{0, 0};
  int cur[2] = '{500, 250};
  always @(negedge clk) begin
    for (int g = 0; g < 2; g++) begin
      logic v;
      if (!en[g]) begin v = 0; ph[g] = 0; end
      else begin
        if (ph[g] == 0) cur[g] = per[g];
        v = (ph[g] < cur[g] / 2);
        ph[g] = (ph[g] + 1 >= cur[g]) ? 0 : ph[g] + 1;
      end
      if (g == 0) lo_sq = v; else hi_sq = v;
    end
  end

  // reference model
  int h1[2], h2[2], h3[2], mcnt[2], marm[2], mrun[2], mlast[2], mval[2];
  int exp_cond, exp_key;
  always @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      if (!rst_n) begin
        h1[g] = 0; h2[g] = 0; h3[g] = 0; mcnt[g] = 0; marm[g] = 0;
        mrun[g] = 0; mlast[g] = 0; mval[g] = 0;
      end else begin
        int tmo, found;
        bit r;
        r = (h2[g] == 1) && (h3[g] == 0);
        h3[g] = h2[g]; h2[g] = h1[g]; h1[g] = (g == 0) ? lo_sq : hi_sq;
        tmo = $rtoi($floor(CLK_HZ * 1.035 / freqs[g][0]));
        if (r) begin
          if (marm[g]) begin
            found = -1;
            for (int i = 0; i < 4; i++)
              if (mcnt[g] >= $rtoi($floor(CLK_HZ * 40.0 / (freqs[g][i] * 41.0))) &&
                  mcnt[g] <= $rtoi($floor(CLK_HZ * 40.0 / (freqs[g][i] * 39.0)))) found = i;
            if (found < 0) begin mrun[g] = 0; mval[g] = 0; end
            else begin
              if (mrun[g] > 0 && found == mlast[g]) mrun[g] = (mrun[g] < MATCH_N) ? mrun[g] + 1 : MATCH_N;
              else mrun[g] = 1;
              mlast[g] = found;
              mval[g] = (mrun[g] == MATCH_N);
            end
          end
          marm[g] = 1; mcnt[g] = 1;
        end else if (marm[g] && mcnt[g] >= tmo) begin
          marm[g] = 0; mrun[g] = 0; mval[g] = 0;
        end else if (mcnt[g] < tmo) mcnt[g]++;
      end
    end
    exp_cond = mval[0] && mval[1];
    exp_key  = exp_cond ? char_code(grid[mlast[0] * 4 + mlast[1]]) : 0;
  end

  // cycle comparison (R7, R8, R9)
  always @(negedge clk) if (rst_n) begin
    compared++;
    if (sig_cond !== exp_cond[0]) begin
      mismatched++;
      $display("FAIL R7 sig_cond actual=%b expected=%0d t=%0t", sig_cond, exp_cond, $time);
    end
    if (key !== exp_key[3:0]) begin
      mismatched++;
      $display("FAIL R8 key actual=%b expected=%b t=%0t", key, exp_key[3:0], $time);
    end
  end

  task automatic chk(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic run_all();
    cyc(5);
    chk("R10 reset sig_cond", sig_cond, 0);
    chk("R10 reset key", key, 0);
    rst_n = 1;
    // R8 R3: every key of the grid
    for (int k = 0; k < 16; k++) begin
      per[0] = per_of(freqs[0][k / 4]);
      per[1] = per_of(freqs[1][k % 4]);
      en[0] = 1; en[1] = 1;
      cyc(7 * per[0]);
      chk("R3 sig_cond after run", sig_cond, 1);
      chk("R8 key code", key, char_code(grid[k]));
    end
    // R5: one stray period in the low stream
    @(posedge lo_sq); per[0] = 494;
    @(posedge lo_sq); per[0] = per_of(941);
    @(posedge lo_sq); cyc(10);
    chk("R5 stray period drops", sig_cond, 0);
    chk("R9 key idle", key, 0);
    cyc(6 * per[0]);
    chk("R3 recovered", sig_cond, 1);
    // R4: switch low tone, validity needs a new run
    @(posedge lo_sq); per[0] = per_of(697);
    @(posedge lo_sq); cyc(2 * per[0] + 10);
    chk("R4 switch not yet valid", sig_cond, 0);
    cyc(4 * per[0]);
    chk("R4 new tone valid", sig_cond, 1);
    chk("R8 key after switch", key, char_code("A"));
    // R1: tolerance edges
    per[0] = per_of(697 * 1.0179); per[1] = per_of(1633 * 0.9838);
    cyc(7 * per[0]);
    chk("R1 accept edge", sig_cond, 1);
    per[0] = per_of(770 * 1.04);
    cyc(7 * per[0]);
    chk("R1 reject 4 percent", sig_cond, 0);
    per[0] = per_of(770); per[1] = per_of(1336);
    cyc(7 * per[0]);
    chk("R1 nominal", key, char_code("5"));
    // R6: silence on the low input
    @(posedge lo_sq); en[0] = 0;
    cyc(480);
    chk("R6 no early drop", sig_cond, 1);
    cyc(80);
    chk("R6 timeout drop", sig_cond, 0);
    // R7 R9: high group alone
    cyc(600);
    chk("R7 one group only", sig_cond, 0);
    chk("R9 key zero", key, 0);
    // R2: re-arm after timeout
    en[0] = 1;
    cyc(3 * per[0]);
    chk("R2 first edge only arms", sig_cond, 0);
    cyc(4 * per[0]);
    chk("R2 rearmed", sig_cond, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL R3 watchdog expired");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule